// File: doc/BRIEF.md
# Packet Payload XOR Stage

This block sits in line in a packet pipeline. It takes 64-bit words with an 8-bit control tag over a write/ready handshake and sends them on over the same kind of handshake. It leaves the routing information of every frame as it is and scrambles the rest. Each packet starts with one or more module header words. These are followed by frame data whose first 34 bytes are the Ethernet header (14 bytes) and an option-free IPv4 header (20 bytes). The block passes those words unchanged and XORs every later byte with a 32-bit key, repeated across the word. Applying the same key a second time restores the original payload, so one stage serves as both encryptor and decryptor.

Because 34 is not a multiple of the 8-byte word, the fifth data word is split. Its two upper bytes end the IPv4 header and pass unchanged; its six lower bytes are the first payload bytes and are XORed. A small fall-through FIFO decouples the input from the output. A register port lets software write and read the key. The block copies the key into the packet's working key at the first data word of each packet, so one packet is never coded with two keys.

Top module: `payload_xor_stage`

## Requirements
- R1: A word with a nonzero `in_ctrl` that arrives while no packet data is in progress is a module header word. It leaves with data and ctrl unchanged.
- R2: The first data word (ctrl = 0) starts a packet. Counting data words from 0, words 0 to 3 leave with data unchanged.
- R3: In data word 4, bits 63:48 (frame bytes 33 and 34, most significant byte first in the word) leave unchanged. Bits 47:0 leave XORed with bits 47:0 of `{key, key}`.
- R4: Data words 5 and later leave as `in_data ^ {key, key}`.
- R5: `out_ctrl` equals the ctrl of the same word. A nonzero ctrl on a data word marks the packet's last word, even before word 4. The next nonzero-ctrl word is then handled as a module header of a new packet.
- R6: Feeding the block's output back through it with the same key yields the original words.
- R7: A `cfg_wr` at `cfg_addr` 0 loads `cfg_wdata` into the key register. `cfg_rdata` shows the key when `cfg_addr` is 0 and 0 at any other address. Writes to other addresses have no effect on the key.
- R8: The key is sampled when a packet's first data word leaves. A key write made later in that packet is used only from the next packet on.
- R9: `out_wr` is high only while `out_rdy` is high. Words leave in arrival order, none lost or repeated. `in_rdy` falls after `FIFO_DEPTH` (4) words are held with no output taken.
- R10: After reset `in_rdy` is 1, `out_wr` is 0, the key reads 0 and the next ctrl-nonzero word counts as a module header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_data | input | 64 | Incoming word |
| in_ctrl | input | 8 | Control tag of incoming word |
| in_wr | input | 1 | Upstream offers a word |
| in_rdy | output | 1 | Block can accept a word |
| out_data | output | 64 | Outgoing word, payload bytes XORed |
| out_ctrl | output | 8 | Control tag of outgoing word |
| out_wr | output | 1 | Outgoing word is transferred this cycle |
| out_rdy | input | 1 | Downstream can accept a word |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |

## Verification
Packets are sent with one to three module header words and with two to twelve data words. This shows whether the header skip ends at the right word and whether the split lands on data word 4 every time. Short packets that end before the split word are sent back-to-back with long ones, which shows that a packet end returns the state machine to header skipping from every phase. Keys of all zeros, all ones and mixed bits separate the pass-through bytes from the XORed ones. A round trip through the block checks that the cipher is its own inverse. Output stalls, a full FIFO and a key write in the middle of a packet check ordering, backpressure and the per-packet key sampling.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    // Position of the stream relative to the frame's header boundary.
    typedef enum logic [1:0] {
        ST_SKIP  = 2'd0,  // between packets or on module header words
        ST_HEAD  = 2'd1,  // inside the plaintext frame header words
        ST_SPLIT = 2'd2,  // word holding the header/payload boundary
        ST_BODY  = 2'd3   // payload words
    } pxs_state_e;

endpackage

// File: rtl/pxs_fifo.sv
module pxs_fifo #(
    parameter int W     = 72,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         ready,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] rdata
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign ready   = (st_q.cnt != CW'(DEPTH));
    assign valid   = (st_q.cnt != '0);
    assign do_push = push && ready;
    assign do_pop  = pop && valid;
    assign rdata   = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + PW'(1);
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + PW'(1);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= wdata;
    end

endmodule

// File: rtl/pxs_key_reg.sv
module pxs_key_reg #(
    parameter int KEY_W    = 32,
    parameter int ADDR_W   = 2,
    parameter int KEY_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [KEY_W-1:0]  cfg_wdata,
    output logic [KEY_W-1:0]  cfg_rdata,
    output logic [KEY_W-1:0]  key_o
);
    logic [KEY_W-1:0] key_d, key_q;
    logic             hit;

    assign hit = (cfg_addr == ADDR_W'(KEY_ADDR));

    always_comb begin
        key_d = key_q;
        if (cfg_wr && hit) key_d = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= '0;
        else        key_q <= key_d;
    end

    assign cfg_rdata = hit ? key_q : '0;
    assign key_o     = key_q;

endmodule

// File: rtl/pxs_cipher_fsm.sv
module pxs_cipher_fsm
    import pxs_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int CTRL_W    = 8,
    parameter int KEY_W     = 32,
    parameter int HDR_BYTES = 34   // must be at least one word
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic [DATA_W-1:0] head_data,
    input  logic [CTRL_W-1:0] head_ctrl,
    input  logic [KEY_W-1:0]  key_cfg,
    output logic [DATA_W-1:0] out_data,
    output pxs_state_e        state_o,
    output logic [KEY_W-1:0]  key_act_o
);
    localparam int BYTES      = DATA_W / 8;
    localparam int PASS_WORDS = HDR_BYTES / BYTES;
    localparam int KEEP_BYTES = HDR_BYTES % BYTES;
    localparam int KEEP_BITS  = KEEP_BYTES * 8;
    localparam int REPS       = DATA_W / KEY_W;
    localparam int CNT_W      = $clog2(PASS_WORDS + 1);
    localparam logic [DATA_W-1:0] SPLIT_MASK = {DATA_W{1'b1}} >> KEEP_BITS;

    typedef struct packed {
        pxs_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [KEY_W-1:0] key;
    } fsm_st_t;

    fsm_st_t           st_d, st_q;
    logic [DATA_W-1:0] key_rep;
    logic [DATA_W-1:0] xor_mask;
    pxs_state_e        after_head;

    for (genvar g = 0; g < REPS; g++) begin : g_rep
        assign key_rep[g*KEY_W +: KEY_W] = st_q.key;
    end

    always_comb begin
        after_head = (KEEP_BYTES != 0) ? ST_SPLIT : ST_BODY;
        st_d       = st_q;
        case (st_q.state)
            ST_SPLIT: xor_mask = SPLIT_MASK;
            ST_BODY:  xor_mask = '1;
            default:  xor_mask = '0;
        endcase

        if (pop) begin
            case (st_q.state)
                ST_SKIP: begin
                    if (head_ctrl == '0) begin
                        st_d.key   = key_cfg;
                        st_d.cnt   = CNT_W'(1);
                        st_d.state = (PASS_WORDS <= 1) ? after_head : ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    if (head_ctrl != '0) begin
                        st_d.state = ST_SKIP;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                        if (st_q.cnt == CNT_W'(PASS_WORDS - 1)) st_d.state = after_head;
                    end
                end
                ST_SPLIT: begin
                    st_d.state = (head_ctrl != '0) ? ST_SKIP : ST_BODY;
                end
                default: begin
                    if (head_ctrl != '0) st_d.state = ST_SKIP;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_SKIP;
            st_q.cnt   <= '0;
            st_q.key   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data  = head_data ^ (key_rep & xor_mask);
    assign state_o   = st_q.state;
    assign key_act_o = st_q.key;

endmodule

// File: rtl/payload_xor_stage.sv
module payload_xor_stage
    import pxs_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int CTRL_W     = 8,
    parameter int KEY_W      = 32,
    parameter int ADDR_W     = 2,
    parameter int FIFO_DEPTH = 4,
    parameter int HDR_BYTES  = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CTRL_W-1:0] in_ctrl,
    input  logic              in_wr,
    output logic              in_rdy,
    output logic [DATA_W-1:0] out_data,
    output logic [CTRL_W-1:0] out_ctrl,
    output logic              out_wr,
    input  logic              out_rdy,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [KEY_W-1:0]  cfg_wdata,
    output logic [KEY_W-1:0]  cfg_rdata
);
    localparam int WORD_W = DATA_W + CTRL_W;

    logic [WORD_W-1:0] head_word;
    logic [DATA_W-1:0] head_data;
    logic [CTRL_W-1:0] head_ctrl;
    logic              head_valid;
    logic [KEY_W-1:0]  key_cfg;
    logic [KEY_W-1:0]  key_act;
    pxs_state_e        fsm_state;

    pxs_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_wr),
        .wdata ({in_ctrl, in_data}),
        .ready (in_rdy),
        .pop   (out_wr),
        .valid (head_valid),
        .rdata (head_word)
    );

    assign head_data = head_word[DATA_W-1:0];
    assign head_ctrl = head_word[WORD_W-1:DATA_W];

    pxs_key_reg #(.KEY_W(KEY_W), .ADDR_W(ADDR_W), .KEY_ADDR(0)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .key_o     (key_cfg)
    );

    pxs_cipher_fsm #(
        .DATA_W(DATA_W), .CTRL_W(CTRL_W), .KEY_W(KEY_W), .HDR_BYTES(HDR_BYTES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (out_wr),
        .head_data (head_data),
        .head_ctrl (head_ctrl),
        .key_cfg   (key_cfg),
        .out_data  (out_data),
        .state_o   (fsm_state),
        .key_act_o (key_act)
    );

    assign out_wr   = head_valid && out_rdy;
    assign out_ctrl = head_ctrl;

endmodule

// File: rtl/pxs_checker.sv
module pxs_checker
    import pxs_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int CTRL_W    = 8,
    parameter int KEY_W     = 32,
    parameter int KEEP_BITS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_wr,
    input logic              out_rdy,
    input logic [DATA_W-1:0] out_data,
    input logic [CTRL_W-1:0] out_ctrl,
    input logic [DATA_W-1:0] head_data,
    input pxs_state_e        state,
    input logic [KEY_W-1:0]  key_act
);
    AST_BLOCKED_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !out_rdy |-> !out_wr); // R9

    AST_MOD_HDR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && state == ST_SKIP) |-> out_data == head_data); // R1

    AST_FRAME_HDR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && state == ST_HEAD) |-> out_data == head_data); // R2

    AST_SPLIT_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && state == ST_SPLIT) |->
            out_data[DATA_W-1 -: KEEP_BITS] == head_data[DATA_W-1 -: KEEP_BITS]); // R3

    AST_END_TO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && state != ST_SKIP && out_ctrl != '0) |=> state == ST_SKIP); // R5

    AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SKIP && $past(state) != ST_SKIP) |-> $stable(key_act)); // R8

endmodule

bind payload_xor_stage pxs_checker #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .KEY_W(KEY_W),
    .KEEP_BITS((HDR_BYTES % (DATA_W / 8)) * 8)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_wr    (out_wr),
    .out_rdy   (out_rdy),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl),
    .head_data (head_data),
    .state     (fsm_state),
    .key_act   (key_act)
);

// File: tb/payload_xor_stage_test.sv
module payload_xor_stage_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int NV         = 6;
    localparam int VH [NV] = '{1, 2, 3, 1, 1, 2};
    localparam int VD [NV] = '{8, 5, 4, 12, 6, 2};
    localparam logic [31:0] VK [NV] = '{32'hA5A50F0F, 32'h12345678, 32'hDEADBEEF,
                                        32'h00000000, 32'hFFFFFFFF, 32'h13572468};
    localparam int VS [NV] = '{0, 1, 0, 2, 1, 0};

    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        in_wr = 0;
    logic        in_rdy;
    logic [63:0] out_data;
    logic [7:0]  out_ctrl;
    logic        out_wr;
    logic        out_rdy = 1;
    logic        cfg_wr = 0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    payload_xor_stage uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl), .in_wr(in_wr),
        .in_rdy(in_rdy), .out_data(out_data), .out_ctrl(out_ctrl), .out_wr(out_wr),
        .out_rdy(out_rdy), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [63:0] got_d [0:1023];
    logic [7:0]  got_c [0:1023];
    int          got_n = 0;
    always @(negedge clk) begin
        if (rst_n && out_wr && got_n < 1024) begin
            got_d[got_n] = out_data;
            got_c[got_n] = out_ctrl;
            got_n++;
        end
    end

    int stall_mode = 0;
    int cyc = 0;
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        case (stall_mode)
            1:       out_rdy = cyc[0];
            2:       out_rdy = (cyc % 3) != 0;
            3:       out_rdy = 1'b0;
            default: out_rdy = 1'b1;
        endcase
    end

    logic [63:0] tx_d [0:63];
    logic [7:0]  tx_c [0:63];
    int          tx_n;
    logic [63:0] ex_d [0:63];
    logic [7:0]  ex_c [0:63];
    int          ex_r [0:63];
    int          ex_n;
    logic [63:0] keep_d [0:63];

    function automatic string tag(int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            6: return "R6";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [63:0] pat(int seed, int i);
        return {32'(seed * 32'h01010101 + i), 32'(seed ^ (i << 8) ^ 32'h5A000000)};
    endfunction

    function automatic logic [63:0] enc(logic [63:0] d, int j, logic [31:0] k);
        logic [63:0] kk = {k, k};
        if (j < 4) return d;
        if (j == 4) return d ^ (kk & 64'h0000_FFFF_FFFF_FFFF);
        return d ^ kk;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_bufs();
        tx_n = 0;
        ex_n = 0;
    endtask

    // Appends one packet: h module headers, dn data words (dn >= 2), coded with key k.
    task automatic add_pkt(int h, int dn, int seed, logic [31:0] k);
        for (int i = 0; i < h; i++) begin
            tx_d[tx_n] = pat(seed + 100, i);
            tx_c[tx_n] = 8'hFF - 8'(i);
            ex_d[ex_n] = tx_d[tx_n];
            ex_c[ex_n] = tx_c[tx_n];
            ex_r[ex_n] = 1;
            tx_n++; ex_n++;
        end
        for (int j = 0; j < dn; j++) begin
            tx_d[tx_n] = pat(seed, j);
            tx_c[tx_n] = (j == dn - 1) ? 8'h04 : 8'h00;
            ex_d[ex_n] = enc(tx_d[tx_n], j, k);
            ex_c[ex_n] = tx_c[tx_n];
            ex_r[ex_n] = (j < 4) ? 2 : ((j == 4) ? 3 : 4);
            tx_n++; ex_n++;
        end
    endtask

    task automatic send_range(int from, int upto);
        int i = from;
        while (i < upto) begin
            in_wr = 1;
            in_data = tx_d[i];
            in_ctrl = tx_c[i];
            @(negedge clk);
            if (in_rdy) i++;
            @(posedge clk); #1;
        end
        in_wr = 0;
    endtask

    task automatic drain();
        repeat (40) @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(logic [1:0] a, logic [31:0] v);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_wr = 0; cfg_addr = '0;
    endtask

    // force_r = 0 uses each word's own requirement tag
    task automatic compare(int base, int force_r);
        check(got_n - base == ex_n, "R9", 64'(got_n - base), 64'(ex_n));
        for (int i = 0; i < ex_n && base + i < got_n; i++) begin
            check(got_d[base + i] == ex_d[i], tag(force_r != 0 ? force_r : ex_r[i]),
                  got_d[base + i], ex_d[i]);
            check(got_c[base + i] == ex_c[i], "R5", 64'(got_c[base + i]), 64'(ex_c[i]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        int acc_n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R10: idle state after reset
        check(in_rdy == 1'b1, "R10", 64'(in_rdy), 64'd1);
        check(out_wr == 1'b0, "R10", 64'(out_wr), 64'd0);
        check(cfg_rdata == 32'd0, "R10", 64'(cfg_rdata), 64'd0);
        @(posedge clk); #1;

        // R7: key register access and address decode
        cfg_write(2'd0, 32'hCAFE0001);
        #1 check(cfg_rdata == 32'hCAFE0001, "R7", 64'(cfg_rdata), 64'hCAFE0001);
        cfg_write(2'd1, 32'h11111111);
        cfg_write(2'd3, 32'h22222222);
        cfg_addr = 2'd0; #1;
        check(cfg_rdata == 32'hCAFE0001, "R7", 64'(cfg_rdata), 64'hCAFE0001);
        cfg_addr = 2'd1; #1;
        check(cfg_rdata == 32'd0, "R7", 64'(cfg_rdata), 64'd0);
        cfg_addr = 2'd0;
        @(posedge clk); #1;

        // R1..R5 and R9: table of packets
        for (int v = 0; v < NV; v++) begin
            stall_mode = VS[v];
            cfg_write(2'd0, VK[v]);
            clear_bufs();
            add_pkt(VH[v], VD[v], 10 + v, VK[v]);
            base = got_n;
            send_range(0, tx_n);
            drain();
            compare(base, 0);
        end
        stall_mode = 0;

        // R5: back-to-back packets, one ending before the split word
        cfg_write(2'd0, 32'h0BADF00D);
        clear_bufs();
        add_pkt(2, 6, 60, 32'h0BADF00D);
        add_pkt(1, 3, 61, 32'h0BADF00D);
        add_pkt(1, 7, 62, 32'h0BADF00D);
        base = got_n;
        send_range(0, tx_n);
        drain();
        compare(base, 0);

        // R6: round trip restores the original
        cfg_write(2'd0, 32'h5EC0DE77);
        clear_bufs();
        add_pkt(1, 10, 77, 32'h5EC0DE77);
        for (int i = 0; i < tx_n; i++) keep_d[i] = tx_d[i];
        base = got_n;
        send_range(0, tx_n);
        drain();
        for (int i = 0; i < tx_n; i++) begin
            tx_d[i] = got_d[base + i];
            ex_d[i] = keep_d[i];
        end
        base = got_n;
        send_range(0, tx_n);
        drain();
        compare(base, 6);

        // R8: key written mid-packet applies to the next packet only
        cfg_write(2'd0, 32'h11223344);
        clear_bufs();
        add_pkt(1, 8, 40, 32'h11223344);
        base = got_n;
        send_range(0, 5);
        cfg_write(2'd0, 32'h99AABBCC);
        send_range(5, tx_n);
        drain();
        compare(base, 8);
        clear_bufs();
        add_pkt(1, 8, 41, 32'h99AABBCC);
        base = got_n;
        send_range(0, tx_n);
        drain();
        compare(base, 8);

        // R9: FIFO fills under a stalled output, then drains in order
        stall_mode = 3;
        @(posedge clk); #2;
        clear_bufs();
        add_pkt(1, 8, 50, 32'h99AABBCC);
        base = got_n;
        acc_n = 0;
        for (int t = 0; t < 8; t++) begin
            in_wr = 1;
            in_data = tx_d[acc_n];
            in_ctrl = tx_c[acc_n];
            @(negedge clk);
            check(out_wr == 1'b0, "R9", 64'(out_wr), 64'd0);
            if (in_rdy) acc_n++;
            @(posedge clk); #1;
        end
        in_wr = 0;
        check(acc_n == DEPTH, "R9", 64'(acc_n), 64'(DEPTH));
        @(negedge clk);
        check(in_rdy == 1'b0, "R9", 64'(in_rdy), 64'd0);
        @(posedge clk); #1;
        stall_mode = 0;
        send_range(acc_n, tx_n);
        drain();
        compare(base, 0);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule